// File: doc/BRIEF.md
# Staged-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output from an 8-bit period timer. A four-phase clock divider produces a quarter-rate tick. An optional prescaler of 4 or 16 slows that tick, and the 8-bit timer counts it from zero up to the programmed period value. Two low-order bits join the timer to form a 10-bit time base. At 1:1 these bits come from the clock-phase divider, and otherwise they come from the low bits of the prescaler count. The output rises at the start of each period. It falls when the time base reaches the active duty value.

Software writes the duty value in two parts at any time. A byte register holds the high eight bits, and the low two bits sit in the control register. The written value is only staged. It moves into a read-only active register at the first period after enable, and at every later period rollover, so a duty change never produces a torn cycle. A one-cycle pulse marks each rollover. The active duty value is visible on the ports.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the output, the rollover pulse and the active duty value are all zero, and the block is disabled.
- R2: While enabled, `period_match` pulses high for exactly one cycle per period, and consecutive pulses are (P+1)·4·D clocks apart. P is the period register and D is the prescale divide.
- R3: The prescale field is control bits [3:2]. Value 0 selects divide 1, value 1 selects divide 4, and values 2 and 3 both select divide 16.
- R4: A write to the duty parts leaves `duty_active` unchanged until the next period start. At that start `duty_active` takes the staged value {duty high byte, duty low bits}.
- R5: With a non-zero active duty d and d < (P+1)·4, the output is high from the first cycle of the period. At divide 1 it stays high for d clocks, and at divide 4 for 4·d clocks.
- R6: With an active duty of zero, the output stays low for the whole period.
- R7: With an active duty of (P+1)·4 or more, the output stays high for the whole period.
- R8: When the enable bit is 0, the output is low from the cycle after the write and the timer is held at zero. When enable returns to 1, the next clock starts a period and loads the staged duty.
- R9: Address 0 writes the period, and address 1 writes the duty high byte. Address 2 writes the control register: duty low bits in [1:0], prescale in [3:2] and enable in [4].
- R10: At divide 16 the two extension bits are the low bits of the prescaler count. The high time is therefore 4·(16·⌊d/4⌋ + (d mod 4)) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output level |
| period_match | output | 1 | One-cycle pulse at the start of each period after rollover |
| duty_active | output | 10 | Active (slave) duty value, read-only |

## Verification
A timer or prescaler count that is off by one shows up at the ports within one period as a shifted `period_match` pulse. A wrong extension-bit source changes the high time in the first period run at that prescale. A duty value copied too early moves `duty_active` in the cycle after the write, where the every-clock comparison catches it at once. A missed zero-duty suppression or a missed clearing match distorts `pwm_out` within the same period.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int EXT_W = 2;
  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV4   = 2'b01,
    PS_DIV16A = 2'b10,
    PS_DIV16B = 2'b11
  } presc_e;

  typedef enum logic [1:0] {
    ADDR_PERIOD  = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_NONE    = 2'd3
  } addr_e;

  // Last prescaler count before a timer increment.
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
    case (sel)
      PS_DIV1: presc_last = 4'd0;
      PS_DIV4: presc_last = 4'd3;
      default: presc_last = 4'd15;
    endcase
  endfunction

  // Extension bits: phase counter at 1:1, low prescaler bits otherwise.
  function automatic logic [EXT_W-1:0] ext_bits(input logic [1:0] sel,
                                                input logic [1:0] phase,
                                                input logic [PRE_W-1:0] pre);
    ext_bits = (sel == PS_DIV1) ? phase : pre[EXT_W-1:0];
  endfunction
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [TMR_W-1:0] period,
  output logic [TMR_W-1:0] duty_hi,
  output logic [EXT_W-1:0] duty_lo,
  output logic [1:0]       presc,
  output logic             en,
  output logic             ctrl_wr
);
  localparam int EN_BIT = 4;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      duty_hi <= '0;
      duty_lo <= '0;
      presc   <= PS_DIV1;
      en      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD:  period  <= wr_data;
        ADDR_DUTY_HI: duty_hi <= wr_data;
        ADDR_CTRL: begin
          duty_lo <= wr_data[EXT_W-1:0];
          presc   <= wr_data[3:2];
          en      <= wr_data[EN_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [1:0]             presc,
  input  logic [TMR_W-1:0]       period,
  output logic [TMR_W-1:0]       tmr,
  output logic                   start_evt,
  output logic                   rollover_evt,
  output logic                   adv,
  output logic [TMR_W+EXT_W-1:0] nxt_base,
  output logic                   period_match
);
  logic [1:0]       phase_r, phase_n;
  logic [PRE_W-1:0] pre_r, pre_n, pre_end;
  logic [TMR_W-1:0] tmr_r, tmr_n;
  logic             started_r;
  logic             running, quarter_end, inc;

  assign pre_end     = presc_last(presc);
  assign running     = en && started_r;
  assign quarter_end = (phase_r == 2'd3);
  assign inc         = running && quarter_end && (pre_r == pre_end);
  assign start_evt    = en && !started_r;
  assign rollover_evt = inc && (tmr_r == period);
  assign adv          = running && ((presc == PS_DIV1) || quarter_end);

  always_comb begin
    phase_n = '0;
    pre_n   = '0;
    tmr_n   = '0;
    if (running) begin
      phase_n = phase_r + 2'd1;
      pre_n   = pre_r;
      tmr_n   = tmr_r;
      if (quarter_end) begin
        if (pre_r == pre_end) begin
          pre_n = '0;
          tmr_n = (tmr_r == period) ? '0 : tmr_r + 1'b1;
        end else begin
          pre_n = pre_r + 1'b1;
        end
      end
    end
  end

  assign nxt_base = {tmr_n, ext_bits(presc, phase_n, pre_n)};
  assign tmr      = tmr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r      <= '0;
      pre_r        <= '0;
      tmr_r        <= '0;
      started_r    <= 1'b0;
      period_match <= 1'b0;
    end else begin
      phase_r      <= phase_n;
      pre_r        <= pre_n;
      tmr_r        <= tmr_n;
      started_r    <= en;
      period_match <= rollover_evt;
    end
  end
endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_evt,
  input  logic [DUTY_W-1:0] staged,
  input  logic              adv,
  input  logic [DUTY_W-1:0] nxt_base,
  output logic              clr_evt,
  output logic [DUTY_W-1:0] duty_active,
  output logic              pwm_out
);
  logic pwm_q;

  assign clr_evt = adv && (nxt_base == duty_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_active <= '0;
      pwm_q       <= 1'b0;
    end else if (!en) begin
      pwm_q <= 1'b0;
    end else if (load_evt) begin
      duty_active <= staged;
      pwm_q       <= (staged != '0);
    end else if (clr_evt) begin
      pwm_q <= 1'b0;
    end
  end

  assign pwm_out = pwm_q && en;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [TMR_W-1:0]       wr_data,
  output logic                   pwm_out,
  output logic                   period_match,
  output logic [TMR_W+EXT_W-1:0] duty_active
);
  localparam int DUTY_W = TMR_W + EXT_W;

  logic [TMR_W-1:0]  period, duty_hi, tmr;
  logic [EXT_W-1:0]  duty_lo;
  logic [1:0]        presc;
  logic              en, ctrl_wr;
  logic              start_evt, rollover_evt, adv, clr_evt, load_evt;
  logic [DUTY_W-1:0] staged, nxt_base;

  pwm10_regs #(.TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .duty_hi(duty_hi),
    .duty_lo(duty_lo), .presc(presc), .en(en), .ctrl_wr(ctrl_wr)
  );

  assign staged   = {duty_hi, duty_lo};
  assign load_evt = start_evt || rollover_evt;

  pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .period(period),
    .tmr(tmr), .start_evt(start_evt), .rollover_evt(rollover_evt),
    .adv(adv), .nxt_base(nxt_base), .period_match(period_match)
  );

  pwm10_duty #(.DUTY_W(DUTY_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .en(en), .load_evt(load_evt),
    .staged(staged), .adv(adv), .nxt_base(nxt_base), .clr_evt(clr_evt),
    .duty_active(duty_active), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int TMR_W  = 8,
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ctrl_wr,
  input logic              start_evt,
  input logic              rollover_evt,
  input logic [DUTY_W-1:0] staged,
  input logic [DUTY_W-1:0] duty_active,
  input logic              pwm_out,
  input logic              period_match,
  input logic [TMR_W-1:0]  tmr
);
  p_match_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_evt |=> period_match);

  p_match_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_match |=> !period_match);

  p_slave_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt || rollover_evt) |=> $stable(duty_active));

  p_slave_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || rollover_evt) |=> (duty_active == $past(staged)));

  p_set_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover_evt && (staged != '0) && !ctrl_wr) |=> pwm_out);

  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover_evt && (staged == '0)) |=> !pwm_out);

  p_off_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr == '0));
endmodule

bind pwm10_gen pwm10_chk #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ctrl_wr(ctrl_wr),
  .start_evt(start_evt), .rollover_evt(rollover_evt), .staged(staged),
  .duty_active(duty_active), .pwm_out(pwm_out),
  .period_match(period_match), .tmr(tmr)
);

// File: tb/test_pwm10_gen.sv
`timescale 1ns/1ps
module test_pwm10_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, period_match;
  logic [9:0] duty_active;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm10_gen i_pwm10_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_match(period_match),
    .duty_active(duty_active)
  );

  // ---------------- reference model ----------------
  int m_per, m_dhi, m_dlo, m_ps, m_en, m_started, m_c, m_act, m_pwm, m_pm;
  int m_div, m_stg;

  function automatic int ps_div(int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  function automatic int tb_base(int c, int div);
    int t, e;
    t = c / (4 * div);
    e = (div == 1) ? (c % 4) : (((c / 4) % div) % 4);
    return t * 4 + e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = 0; m_dhi = 0; m_dlo = 0; m_ps = 0; m_en = 0;
      m_started = 0; m_c = 0; m_act = 0; m_pwm = 0; m_pm = 0;
    end else begin
      m_div = ps_div(m_ps);
      m_stg = m_dhi * 4 + m_dlo;
      m_pm  = 0;
      if (m_en == 0) begin
        m_started = 0; m_c = 0; m_pwm = 0;
      end else if (m_started == 0) begin
        m_started = 1; m_c = 0; m_act = m_stg; m_pwm = (m_stg != 0);
      end else if (m_c + 1 == (m_per + 1) * 4 * m_div) begin
        m_c = 0; m_act = m_stg; m_pwm = (m_stg != 0); m_pm = 1;
      end else begin
        m_c = m_c + 1;
        if (tb_base(m_c, m_div) == m_act) m_pwm = 0;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_per = wr_data;
          2'd1: m_dhi = wr_data;
          2'd2: begin
            m_dlo = wr_data[1:0]; m_ps = wr_data[3:2]; m_en = wr_data[4];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 pwm_out vs model", pwm_out, (m_pwm != 0 && m_en != 0) ? 1 : 0);
      check("R2 period_match vs model", period_match, m_pm);
      check("R4 duty_active vs model", duty_active, m_act);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_high(int d, int div, int per);
    int n;
    n = (per + 1) * 4 * div;
    if (d == 0) return 0;
    if (d >= (per + 1) * 4) return n;
    if (div == 16) return 4 * (16 * (d / 4) + (d % 4));
    return d * div;
  endfunction

  task automatic measure(string tag, int div, int per, int d);
    int n, h, guard;
    guard = 0;
    while (!period_match && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " duty loaded at rollover"}, duty_active, d);
    n = 0; h = 0;
    do begin
      if (pwm_out) h++;
      n++;
      @(negedge clk);
    end while (!period_match && n < 5000);
    check({tag, " period clocks"}, n, (per + 1) * 4 * div);
    check({tag, " high clocks"}, h, exp_high(d, div, per));
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pwm_out", pwm_out, 0);
    check("R1 reset period_match", period_match, 0);
    check("R1 reset duty_active", duty_active, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 register map, start with duty 7 at divide 1, period 4
    wr(0, 4);
    wr(1, 1);
    wr(2, 8'h13);
    check("R4 staged duty not yet active", duty_active, 0);
    @(negedge clk);
    check("R8 start loads staged duty", duty_active, 7);
    check("R5 output high at period start", pwm_out, 1);
    measure("R2 R5 div1 d7", 1, 4, 7);
    measure("R2 R5 div1 d7 again", 1, 4, 7);

    // R4 mid-period duty change is staged
    repeat (5) @(negedge clk);
    wr(1, 3);
    check("R4 mid-period write not active", duty_active, 7);
    measure("R4 R5 div1 d15", 1, 4, 15);

    // R6 zero duty
    wr(1, 0);
    wr(2, 8'h10);
    measure("R6 zero duty", 1, 4, 0);

    // R7 duty at and above full period
    wr(1, 5);
    measure("R7 duty equals period count", 1, 4, 20);
    wr(1, 255);
    wr(2, 8'h13);
    measure("R7 duty 1023", 1, 4, 1023);

    // R8 disable while high
    while (!period_match) @(negedge clk);
    check("R8 high before disable", pwm_out, 1);
    wr(2, 8'h00);
    check("R8 output low after disable", pwm_out, 0);
    repeat (10) @(negedge clk);
    check("R8 still low while disabled", pwm_out, 0);
    check("R8 no rollover while disabled", period_match, 0);

    // R3 divide 4, duty 9
    wr(1, 2);
    wr(2, 8'h15);
    measure("R3 div4 d9", 4, 4, 9);

    // R10 divide 16, duty 6
    wr(2, 8'h00);
    wr(1, 1);
    wr(2, 8'h1A);
    measure("R10 div16 d6", 16, 4, 6);

    // R3 select 3 also divides by 16
    wr(2, 8'h00);
    wr(2, 8'h1E);
    measure("R3 R10 sel3 div16 d6", 16, 4, 6);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=sequence complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule